// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

A small binary counter that steps up or down by one on each rising clock edge when both of its active-low count enables are low, holds otherwise, and can be preset from a parallel data bus through an active-low synchronous load. Load has priority over counting. Counting wraps modulo 2^WIDTH in both directions.

The block exposes a decoded, active-low terminal-count output for building wider counters with no extra gating. This output is low only when the chain enable is low and the registered count sits at its terminal value. The terminal value is all-ones when counting up and zero when counting down. To build a wide counter, tie the count enable of every stage to one shared line. Drive the first stage's chain enable from the system. Feed each later stage's chain enable from the previous stage's terminal-count output.

A parameter picks how the next count is formed. One option is a per-bit toggle lookahead, where bit i flips when all lower bits are all-ones (up) or all-zeros (down). The other is a plain add/subtract.

Top module: `updn_cascade_counter`

## Requirements
- R1: The count register changes only at a rising clock edge; changing load, enables, direction or data between edges leaves the count output unchanged until the next edge.
- R2: When load_n is high and either cnt_en_n or chain_en_n is high at a rising edge, the count holds its value.
- R3: When load_n is high, both enables are low and count_up is 1, the count increments by one at the edge, wrapping from all-ones to zero.
- R4: When load_n is high, both enables are low and count_up is 0, the count decrements by one at the edge, wrapping from zero to all-ones.
- R5: When load_n is low at a rising edge, the count takes din regardless of the enables and direction.
- R6: carry_n is high whenever chain_en_n is high.
- R7: carry_n is low exactly when chain_en_n is low and the count is all-ones with count_up = 1, or zero with count_up = 0; it follows chain_en_n and count_up without waiting for a clock edge.
- R8: Stages chained carry_n to chain_en_n, sharing clock, load, cnt_en_n and count_up, behave as one wider up/down counter with the same load, hold and wrap rules, and the last stage's carry_n marks the wide terminal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en_n | input | 1 | Active-low count enable, does not affect carry |
| chain_en_n | input | 1 | Active-low count enable that also gates carry_n |
| count_up | input | 1 | 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel preset value |
| q | output | WIDTH | Registered count |
| carry_n | output | 1 | Active-low decoded terminal count |

## Verification
On every clock edge after the first load, the assertions check the following: hold when either enable is high, a step of plus or minus one with wrap, load priority, and the gating and decoding of carry_n against the count and the controls. Some behaviour can only be shown by the bench's scenarios. One case is that mid-cycle changes of the controls leave the count alone while carry_n reacts at once. The other is that three chained stages reproduce a 12-bit reference counter through stage borrows and carries in both directions.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_INC  = 2'd1,
      OP_DEC  = 2'd2,
      OP_LOAD = 2'd3
   } cnt_op_e;

   // Load wins over counting; counting needs both enables low.
   function automatic cnt_op_e pick_op(input logic load_n,
                                       input logic cnt_en_n,
                                       input logic chain_en_n,
                                       input logic count_up);
      if (!load_n)
         return OP_LOAD;
      if (cnt_en_n || chain_en_n)
         return OP_HOLD;
      return count_up ? OP_INC : OP_DEC;
   endfunction

endpackage

// File: rtl/updn_step_logic.sv
module updn_step_logic
   import updn_cnt_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  cnt_op_e          op,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("updn_step_logic: WIDTH must be 1..32");
   end

   logic             dir_up;
   logic [WIDTH-1:0] stepped;

   assign dir_up = (op == OP_INC);

   if (LOOKAHEAD) begin : g_lookahead
      // Each bit flips when every lower bit is at the terminal level
      logic [WIDTH-1:0] ones_below;
      logic [WIDTH-1:0] zeros_below;
      logic [WIDTH-1:0] flip;

      assign ones_below[0]  = 1'b1;
      assign zeros_below[0] = 1'b1;
      for (genvar i = 1; i < WIDTH; i++) begin : g_prefix
         assign ones_below[i]  = ones_below[i-1]  &  cur[i-1];
         assign zeros_below[i] = zeros_below[i-1] & ~cur[i-1];
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_flip
         assign flip[i] = dir_up ? ones_below[i] : zeros_below[i];
      end
      assign stepped = cur ^ flip;
   end else begin : g_arith
      assign stepped = dir_up ? (cur + WIDTH'(1)) : (cur - WIDTH'(1));
   end

   always_comb begin
      unique case (op)
         OP_LOAD:        nxt = din;
         OP_INC, OP_DEC: nxt = stepped;
         default:        nxt = cur;
      endcase
   end

endmodule

// File: rtl/updn_state_reg.sv
module updn_state_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("updn_state_reg: WIDTH must be positive");
   end

   // No reset by design: the first synchronous load defines the state.
   always_ff @(posedge clk) begin
      q <= nxt;
   end

endmodule

// File: rtl/updn_terminal_decode.sv
module updn_terminal_decode #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] q,
   input  logic             count_up,
   input  logic             chain_en_n,
   output logic             carry_n
);

   localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] BOT_VAL = '0;

   logic at_top;
   logic at_bot;
   logic term_hit;

   // Decoded from registered bits only, so no counting glitch reaches carry_n
   assign at_top   = (q == TOP_VAL);
   assign at_bot   = (q == BOT_VAL);
   assign term_hit = count_up ? at_top : at_bot;
   assign carry_n  = ~(~chain_en_n & term_hit);

endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
   import updn_cnt_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic             cnt_en_n,
   input  logic             chain_en_n,
   input  logic             count_up,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             carry_n
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("updn_cascade_counter: WIDTH must be 1..32");
   end

   cnt_op_e          op;
   logic [WIDTH-1:0] nxt;

   assign op = pick_op(load_n, cnt_en_n, chain_en_n, count_up);

   updn_step_logic #(
      .WIDTH     (WIDTH),
      .LOOKAHEAD (LOOKAHEAD)
   ) u_step (
      .op  (op),
      .cur (q),
      .din (din),
      .nxt (nxt)
   );

   updn_state_reg #(
      .WIDTH (WIDTH)
   ) u_reg (
      .clk (clk),
      .nxt (nxt),
      .q   (q)
   );

   updn_terminal_decode #(
      .WIDTH (WIDTH)
   ) u_term (
      .q          (q),
      .count_up   (count_up),
      .chain_en_n (chain_en_n),
      .carry_n    (carry_n)
   );

   // Checks are armed once a load has defined the state.
   logic chk_armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!load_n)
         chk_armed <= 1'b1;
   end

   p_hold_r2: assert property (@(posedge clk) disable iff (!chk_armed)
      (load_n && (cnt_en_n || chain_en_n)) |=> (q == $past(q)));

   p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!chk_armed)
      (load_n && !cnt_en_n && !chain_en_n && count_up) |=> (q == $past(q) + WIDTH'(1)));

   p_dec_wrap_r4: assert property (@(posedge clk) disable iff (!chk_armed)
      (load_n && !cnt_en_n && !chain_en_n && !count_up) |=> (q == $past(q) - WIDTH'(1)));

   p_load_first_r5: assert property (@(posedge clk) disable iff (!chk_armed)
      (!load_n) |=> (q == $past(din)));

   p_carry_gated_r6: assert property (@(posedge clk) disable iff (!chk_armed)
      chain_en_n |-> carry_n);

   p_carry_top_r7: assert property (@(posedge clk) disable iff (!chk_armed)
      (!chain_en_n && count_up && q == ALL_ONES) |-> !carry_n);

   p_carry_bot_r7: assert property (@(posedge clk) disable iff (!chk_armed)
      (!chain_en_n && !count_up && q == '0) |-> !carry_n);

   p_carry_only_term_r7: assert property (@(posedge clk) disable iff (!chk_armed)
      (!carry_n) |-> (count_up ? (q == ALL_ONES) : (q == '0)));

endmodule

// File: tb/updn_cascade_counter_tb.sv
`timescale 1ns/1ps
module updn_cascade_counter_tb;

   localparam int W  = 4;
   localparam int NS = 3;
   localparam int TW = W * NS;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          load_n   = 1'b1;
   logic          cnt_en_n = 1'b1;
   logic          chain_n  = 1'b1;
   logic          count_up = 1'b1;
   logic [TW-1:0] din      = '0;
   logic [TW-1:0] q_all;
   logic [NS:0]   tchain;

   assign tchain[0] = chain_n;

   updn_cascade_counter #(.WIDTH(W)) u_dut (
      .clk        (clk),
      .load_n     (load_n),
      .cnt_en_n   (cnt_en_n),
      .chain_en_n (tchain[0]),
      .count_up   (count_up),
      .din        (din[W-1:0]),
      .q          (q_all[W-1:0]),
      .carry_n    (tchain[1])
   );

   for (genvar k = 1; k < NS; k++) begin : g_stage
      updn_cascade_counter #(.WIDTH(W)) u_stage (
         .clk        (clk),
         .load_n     (load_n),
         .cnt_en_n   (cnt_en_n),
         .chain_en_n (tchain[k]),
         .count_up   (count_up),
         .din        (din[k*W +: W]),
         .q          (q_all[k*W +: W]),
         .carry_n    (tchain[k+1])
      );
   end

   typedef struct {
      logic [TW-1:0] val;
      logic          cy;
      string         req;
   } exp_t;

   exp_t          sb[$];
   logic [TW-1:0] ref_cnt = '0;
   int            vectors = 0;
   int            miscompares = 0;

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_carry(input logic t, input logic u, input logic [TW-1:0] v);
      return !(!t && (u ? (v == '1) : (v == '0)));
   endfunction

   // Driver: apply one cycle of controls and push the expected result
   task automatic drive(input logic ld, input logic pp, input logic tt, input logic u,
                        input logic [TW-1:0] d, input string req);
      exp_t e;
      @(negedge clk);
      load_n = ld; cnt_en_n = pp; chain_n = tt; count_up = u; din = d;
      if (!ld)
         ref_cnt = d;
      else if (!pp && !tt)
         ref_cnt = u ? ref_cnt + 1'b1 : ref_cnt - 1'b1;
      e.val = ref_cnt;
      e.cy  = exp_carry(tt, u, ref_cnt);
      e.req = req;
      sb.push_back(e);
   endtask

   // Monitor: compare shortly after each rising edge
   always begin
      exp_t e;
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
         e = sb.pop_front();
         check({e.req, " count"}, int'(q_all), int'(e.val));
         check({e.req, " carry"}, int'(tchain[NS]), int'(e.cy));
      end
   end

   // Mid-cycle probe: controls move between edges, count must not, carry must
   task automatic probe_mid();
      logic [TW-1:0] snap;
      @(negedge clk);
      load_n = 1'b1; cnt_en_n = 1'b1;
      #2;
      snap = q_all;
      count_up = ~count_up;
      #1;
      check("R7 carry follows direction", int'(tchain[NS]), int'(exp_carry(chain_n, count_up, ref_cnt)));
      check("R1 count unchanged by direction", int'(q_all), int'(snap));
      count_up = ~count_up;
      #1;
      check("R7 carry restored", int'(tchain[NS]), int'(exp_carry(chain_n, count_up, ref_cnt)));
      chain_n = 1'b1;
      din = ~snap;
      #1;
      check("R6 carry off with chain enable high", int'(tchain[NS]), 1);
      check("R1 count unchanged by data", int'(q_all), int'(snap));
      chain_n = 1'b0;
      #1;
      check("R7 carry follows chain enable", int'(tchain[NS]), int'(exp_carry(1'b0, count_up, ref_cnt)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      // Known state via load, enables off
      drive(1'b0, 1'b1, 1'b1, 1'b1, 12'h000, "R5 init load");
      repeat (20) drive(1'b1, 1'b0, 1'b0, 1'b1, '0, "R3 up");
      // Up through the wide terminal value and wrap
      drive(1'b0, 1'b0, 1'b0, 1'b1, 12'hFFD, "R5 load with enables low");
      repeat (5) drive(1'b1, 1'b0, 1'b0, 1'b1, '0, "R3/R8 up wrap");
      // Hold on each enable
      repeat (3) drive(1'b1, 1'b1, 1'b0, 1'b1, '0, "R2 hold cnt_en");
      repeat (3) drive(1'b1, 1'b0, 1'b1, 1'b1, '0, "R2 hold chain_en");
      // Down through zero and wrap
      drive(1'b0, 1'b1, 1'b1, 1'b0, 12'h002, "R5 load down");
      repeat (6) drive(1'b1, 1'b0, 1'b0, 1'b0, '0, "R4 down wrap");
      // Borrow across stages
      drive(1'b0, 1'b0, 1'b0, 1'b0, 12'h100, "R5 load down enabled");
      repeat (4) drive(1'b1, 1'b0, 1'b0, 1'b0, '0, "R4/R8 borrow");
      // Long up run crossing middle stage
      drive(1'b0, 1'b1, 1'b1, 1'b1, 12'h0F0, "R5 load");
      repeat (300) drive(1'b1, 1'b0, 1'b0, 1'b1, '0, "R8 up chain");
      // Hold at full value with chain enable low, then high
      drive(1'b0, 1'b1, 1'b0, 1'b1, 12'hFFF, "R5 load top");
      drive(1'b1, 1'b1, 1'b0, 1'b1, '0, "R7 top decode");
      drive(1'b1, 1'b1, 1'b1, 1'b1, '0, "R6 top gated");
      drive(1'b1, 1'b1, 1'b0, 1'b1, '0, "R7 top decode");
      probe_mid();
      drive(1'b1, 1'b1, 1'b0, 1'b0, '0, "R7 no carry down at top");
      // Zero with downward direction
      drive(1'b0, 1'b1, 1'b0, 1'b0, 12'h000, "R5 load zero");
      drive(1'b1, 1'b1, 1'b0, 1'b0, '0, "R7 bottom decode");
      probe_mid();
      repeat (300) drive(1'b1, 1'b0, 1'b0, 1'b0, '0, "R8 down chain");
      drive(1'b1, 1'b1, 1'b1, 1'b0, '0, "R2 final hold");
      repeat (3) @(posedge clk);
      #6;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule